// File: doc/BRIEF.md
# Timer and External Interrupt Control Register

This block is the control and status byte that sits between two counter/timers, two external interrupt pins and the interrupt controller. It drives a run enable to each timer. It holds an overflow flag for each timer and a request flag for each external pin. It samples the pins through a synchronizer and turns a falling edge, or a held low level, into an interrupt request. The timer count chains and the vectoring logic are outside this block.

Software reads and writes the byte through a simple write strobe and a continuously driven read bus. Each flag has two ways to clear. Software can write a zero to the flag bit. Hardware clears the flag when the interrupt controller acknowledges that source. A hardware set that lands in the same cycle as either clear takes priority.

Each pin has its own small tracker with two states, `PIN_HI` and `PIN_LO`, which follow the synchronized level:
- The *falling* transition (`PIN_HI` to `PIN_LO`) emits a one-cycle edge strobe.
- The *rising* transition (`PIN_LO` to `PIN_HI`) emits nothing.

A per-pin type bit chooses between two sensing modes. In edge mode the strobe latches the request flag. In level mode the request output follows the synchronized low level directly.

Top module: `tmr_xint_ctl`

## Requirements
- R1: The read bus shows, from bit 7 down to bit 0: timer-1 overflow flag, timer-1 run, timer-0 overflow flag, timer-0 run, pin-1 request flag, pin-1 type, pin-0 request flag, pin-0 type.
- R2: A write stores bits 6, 4, 2 and 0 as written, and `tmr_run` follows the run bits from the next cycle.
- R3: A one-cycle `tmr_ovf` strobe sets the matching overflow flag on the following clock, and `tmr_irq` equals that flag.
- R4: Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit leaves it unchanged.
- R5: An acknowledge clears only its own source's flag, on the next clock.
- R6: With the type bit at 1 (edge mode), a pin falling from high to low sets its request flag three clocks after the pin changes. A rising pin sets nothing. `xint_irq` equals the flag.
- R7: With the type bit at 0 (level mode), `xint_irq` is high exactly while the pin, delayed by two clocks, is low. The request flag is not set in this mode.
- R8: When a hardware set and a clear (a write of 0 or an acknowledge) hit a flag in the same cycle, the flag ends up set.
- R9: Reset clears the whole byte to zero, so both timers are stopped and both pins are in level mode. The synchronizers reset to high, so leaving reset with a high pin raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current control byte |
| xint_pin | input | 2 | Asynchronous external interrupt pins |
| tmr_ovf | input | 2 | Timer overflow strobes |
| tmr_ack | input | 2 | Acknowledge for the timer interrupts |
| xint_ack | input | 2 | Acknowledge for the pin interrupts |
| tmr_run | output | 2 | Run enable to each timer |
| tmr_irq | output | 2 | Timer interrupt requests |
| xint_irq | output | 2 | Pin interrupt requests |

## Verification
Directed sequences cover several cases:
- Single overflow strobes, and acknowledges on one source while the other stays pending. These separate a correct per-source clear from a shared one.
- A pin that falls and then rises in edge mode. This shows whether the rising transition is wrongly latched, and checks the exact three-cycle latency.
- A pin held low in level mode. This distinguishes level following from flag latching.
- Cycles where a set coincides with a write of 0 or with an acknowledge. These expose a wrong priority.

A long random phase then toggles pins, modes, strobes and writes together. A behavioural model is compared against every output on every clock.

// File: rtl/tx_ctl_pkg.sv
package tx_ctl_pkg;

    localparam int NUM_SRC = 2;

    typedef enum logic [0:0] {
        PIN_HI = 1'b0,
        PIN_LO = 1'b1
    } pin_st_t;

    // bit positions in the control byte, per channel index
    function automatic int type_pos(input int ch);
        return 2 * ch;
    endfunction

    function automatic int xflag_pos(input int ch);
        return 2 * ch + 1;
    endfunction

    function automatic int run_pos(input int ch);
        return 2 * ch + 4;
    endfunction

    function automatic int tflag_pos(input int ch);
        return 2 * ch + 5;
    endfunction

endpackage

// File: rtl/tx_flag_cell.sv
module tx_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end
    end

    // R8: a set always lands, whatever clear arrives with it
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);

    // R4 / R5: a clear without a set empties the flag
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && clr_i) |=> !q_o);

endmodule

// File: rtl/tx_xint_sense.sv
module tx_xint_sense
    import tx_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o,
    output logic low_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          lvl;
    pin_st_t       st_q, st_d;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= pin_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[LAST-1:0], pin_i};
            end
        end
    endgenerate

    assign lvl   = sync_q[LAST];
    assign low_o = ~lvl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PIN_HI;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PIN_HI: if (!lvl) st_d = PIN_LO;
            PIN_LO: if (lvl)  st_d = PIN_HI;
        endcase
    end

    // outputs
    always_comb begin
        fall_o = 1'b0;
        unique case (st_q)
            PIN_HI: fall_o = ~lvl;
            PIN_LO: fall_o = 1'b0;
        endcase
    end

    // R6: an edge strobe never lasts two cycles
    assert_fall_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

    // R6: a strobe is only emitted while the synchronized pin is low
    assert_fall_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> low_o);

endmodule

// File: rtl/tmr_xint_ctl.sv
module tmr_xint_ctl
    import tx_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic [1:0] xint_pin,
    input  logic [1:0] tmr_ovf,
    input  logic [1:0] tmr_ack,
    input  logic [1:0] xint_ack,
    output logic [1:0] tmr_run,
    output logic [1:0] tmr_irq,
    output logic [1:0] xint_irq
);

    logic [NUM_SRC-1:0] run_q, type_q, tf_q, xf_q, fall, low;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            localparam int PT  = type_pos(g);
            localparam int PX  = xflag_pos(g);
            localparam int PR  = run_pos(g);
            localparam int PF  = tflag_pos(g);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    run_q[g]  <= 1'b0;
                    type_q[g] <= 1'b0;
                end else if (reg_wr) begin
                    run_q[g]  <= reg_wdata[PR];
                    type_q[g] <= reg_wdata[PT];
                end
            end

            tx_flag_cell i_tflag (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (tmr_ovf[g]),
                .clr_i ((reg_wr && !reg_wdata[PF]) || tmr_ack[g]),
                .q_o   (tf_q[g])
            );

            tx_xint_sense #(.SYNC_STAGES(SYNC_STAGES)) i_sense (
                .clk    (clk),
                .rst_n  (rst_n),
                .pin_i  (xint_pin[g]),
                .fall_o (fall[g]),
                .low_o  (low[g])
            );

            tx_flag_cell i_xflag (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (fall[g] && type_q[g]),
                .clr_i ((reg_wr && !reg_wdata[PX]) || xint_ack[g]),
                .q_o   (xf_q[g])
            );

            assign reg_rdata[PT] = type_q[g];
            assign reg_rdata[PX] = xf_q[g];
            assign reg_rdata[PR] = run_q[g];
            assign reg_rdata[PF] = tf_q[g];

            assign tmr_run[g]  = run_q[g];
            assign tmr_irq[g]  = tf_q[g];
            assign xint_irq[g] = type_q[g] ? xf_q[g] : low[g];

            // R2: a written run bit reaches the timer enable
            assert_run_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
                reg_wr |=> (tmr_run[g] == $past(reg_wdata[PR])));

            // R3: an overflow strobe always yields a timer request
            assert_ovf_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
                tmr_ovf[g] |=> tmr_irq[g]);

            // R7: in level mode a clear flag stays clear
            assert_level_no_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (!type_q[g] && !xf_q[g] && !reg_wr) |=> !xf_q[g]);
        end
    endgenerate

endmodule

// File: tb/test_tmr_xint_ctl.sv
module test_tmr_xint_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [1:0] xint_pin = 2'b11;
    logic [1:0] tmr_ovf = 2'b00;
    logic [1:0] tmr_ack = 2'b00;
    logic [1:0] xint_ack = 2'b00;
    logic [1:0] tmr_run, tmr_irq, xint_irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tmr_xint_ctl i_tmr_xint_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .xint_pin(xint_pin), .tmr_ovf(tmr_ovf),
        .tmr_ack(tmr_ack), .xint_ack(xint_ack), .tmr_run(tmr_run),
        .tmr_irq(tmr_irq), .xint_irq(xint_irq)
    );

    // behavioural reference
    bit m_tf[2], m_tr[2], m_xf[2], m_ty[2];
    bit m_s1[2], m_s2[2], m_prev[2];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_tf[i] = 0; m_tr[i] = 0; m_xf[i] = 0; m_ty[i] = 0;
                m_s1[i] = 1; m_s2[i] = 1; m_prev[i] = 1;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                bit edge_seen;
                edge_seen = m_prev[i] && !m_s2[i];
                if (tmr_ovf[i]) m_tf[i] = 1;
                else if ((reg_wr && !reg_wdata[2*i+5]) || tmr_ack[i]) m_tf[i] = 0;
                if (edge_seen && m_ty[i]) m_xf[i] = 1;
                else if ((reg_wr && !reg_wdata[2*i+1]) || xint_ack[i]) m_xf[i] = 0;
                if (reg_wr) begin
                    m_tr[i] = reg_wdata[2*i+4];
                    m_ty[i] = reg_wdata[2*i];
                end
                m_prev[i] = m_s2[i];
                m_s2[i] = m_s1[i];
                m_s1[i] = xint_pin[i];
            end
        end
    end

    function automatic logic [7:0] m_byte();
        return {m_tf[1], m_tr[1], m_tf[0], m_tr[0], m_xf[1], m_ty[1], m_xf[0], m_ty[0]};
    endfunction

    function automatic bit m_xirq(input int i);
        return m_ty[i] ? m_xf[i] : !m_s2[i];
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cyc++;
            check("R1 byte", reg_rdata, m_byte());
            check("R2 run", {6'd0, tmr_run}, {6'd0, m_tr[1], m_tr[0]});
            check("R3 tirq", {6'd0, tmr_irq}, {6'd0, m_tf[1], m_tf[0]});
            for (int i = 0; i < 2; i++)
                check(m_ty[i] ? "R6 xirq" : "R7 xirq", {7'd0, xint_irq[i]}, {7'd0, m_xirq(i)});
        end
    end

    task automatic summary();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic step(); @(negedge clk); endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1; reg_wdata = d; step(); reg_wr = 0;
    endtask

    initial begin
        repeat (3) step();
        // R9: reset contents
        check("R9 reset byte", reg_rdata, 8'h00);
        check("R9 reset irq", {4'd0, tmr_irq, xint_irq}, 8'h00);
        rst_n = 1;
        repeat (3) step();
        check("R9 no spurious request", {6'd0, xint_irq}, 8'h00);

        // R2: both run bits on, both pins in edge mode
        wr(8'b0101_0101);
        check("R2 run bits", {6'd0, tmr_run}, 8'h03);
        check("R1 layout", reg_rdata, 8'h55);

        // R3: overflow on timer 0
        tmr_ovf = 2'b01; step(); tmr_ovf = 2'b00;
        check("R3 flag set", {6'd0, tmr_irq}, 8'h01);
        tmr_ovf = 2'b10; step(); tmr_ovf = 2'b00;
        // R5: acknowledge timer 0 only
        tmr_ack = 2'b01; step(); tmr_ack = 2'b00;
        check("R5 ack own only", {6'd0, tmr_irq}, 8'h02);

        // R4: writing 1 keeps, writing 0 clears
        wr(8'b1101_0101);
        check("R4 write one keeps", {6'd0, tmr_irq}, 8'h02);
        wr(8'b0101_0101);
        check("R4 write zero clears", {6'd0, tmr_irq}, 8'h00);

        // R6: falling pin 0 in edge mode, three-cycle latency
        xint_pin[0] = 0; step(); step();
        check("R6 not yet", {7'd0, xint_irq[0]}, 8'h00);
        step();
        check("R6 edge latched", {7'd0, xint_irq[0]}, 8'h01);
        xint_ack = 2'b01; step(); xint_ack = 2'b00;
        check("R5 xint ack", {7'd0, xint_irq[0]}, 8'h00);
        xint_pin[0] = 1; repeat (4) step();
        check("R6 rise ignored", {7'd0, xint_irq[0]}, 8'h00);

        // R8: set and clear in one cycle
        tmr_ovf = 2'b01; tmr_ack = 2'b01; step(); tmr_ovf = 0; tmr_ack = 0;
        check("R8 set beats ack", {7'd0, tmr_irq[0]}, 8'h01);
        tmr_ovf = 2'b10; reg_wr = 1; reg_wdata = 8'b0101_0101; step();
        tmr_ovf = 0; reg_wr = 0;
        check("R8 set beats write", {7'd0, tmr_irq[1]}, 8'h01);

        // R7: pin 1 in level mode
        wr(8'b0101_0001);
        xint_pin[1] = 0; step();
        check("R7 latency", {7'd0, xint_irq[1]}, 8'h00);
        step();
        check("R7 follows low", {7'd0, xint_irq[1]}, 8'h01);
        repeat (3) step();
        check("R7 no flag", {7'd0, reg_rdata[3]}, 8'h00);
        xint_pin[1] = 1; step(); step();
        check("R7 released", {7'd0, xint_irq[1]}, 8'h00);

        // mixed random traffic checked by the model each cycle
        for (int k = 0; k < 3000; k++) begin
            xint_pin = 2'($urandom);
            tmr_ovf  = 2'($urandom % 4 == 0 ? $urandom : 0);
            tmr_ack  = 2'($urandom % 3 == 0 ? $urandom : 0);
            xint_ack = 2'($urandom % 3 == 0 ? $urandom : 0);
            reg_wr   = ($urandom % 8 == 0);
            reg_wdata = 8'($urandom);
            step();
        end
        reg_wr = 0; tmr_ovf = 0; tmr_ack = 0; xint_ack = 0;
        step();
        summary();
    end

endmodule